// File: doc/BRIEF.md
# Selected-Mapping Side-Information Codec

This block carries the 2-bit index of the chosen phase-rotation candidate across the link. The candidate set has four entries, and the index goes out on reserved tones. On the transmit side the index becomes a 5-bit shortened Hamming codeword. Each coded bit is then turned into a BPSK amplitude, one per clock cycle, with the most significant bit first. The amplitude magnitude comes in on a port, so the integrator can trade the power spent on these tones against peak-power reduction and noise robustness.

On the receive side the block takes the five hard decisions for one codeword in a single cycle and computes a 3-bit syndrome. A single bit error is repaired. The syndromes that match no single-bit error raise an uncorrectable flag. The recovered index and both flags come out registered. Choosing the reserved tones and forming the hard decisions are done elsewhere.

Top module: `slm_si_codec`

## Requirements
- R1: Index d (two bits) is encoded as codeword c[4:0] = {d1, d0, d1, d0, d1^d0}, so 00→00000, 01→01011, 10→10101 and 11→11110. Bit c4 is sent first.
- R2: Each coded bit maps to a signed sym_o: 0 → +A and 1 → −A. A is tx_amp_i captured in the cycle the index is accepted and held for the whole frame.
- R3: An index accepted on a rising edge (tx_valid_i with tx_ready_o high) yields exactly five valid symbols, c4 down to c0. These appear in the five cycles that follow the accepting edge. sym_valid_o is low afterwards unless another index was accepted.
- R4: tx_ready_o is low while symbols c3..c0 are still pending. tx_valid_i has no effect while tx_ready_o is low. An index offered in the cycle the last symbol shows is accepted, so frames run with no gap.
- R5: dec_valid_o is high in exactly the cycle after a cycle with rx_valid_i high, and low otherwise.
- R6: The syndrome is s = {r4^r2, r3^r1, r4^r3^r0} on rx_bits_i r[4:0]. When s is zero, dec_idx_o = r[4:3] and both flags are low.
- R7: A nonzero s equal to the syndrome of a single error is corrected. Those syndromes are r4:101, r3:011, r2:100, r1:010 and r0:001. The corrected index is output and dec_fixed_o is 1.
- R8: When s is 110 or 111, dec_err_o is 1 and dec_fixed_o is 0, and dec_idx_o gives the uncorrected r[4:3]. The two flags are never high together.
- R9: After reset, sym_valid_o, dec_valid_o, dec_fixed_o and dec_err_o are 0 and tx_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tx_valid_i | input | 1 | index offered for transmission |
| tx_idx_i | input | 2 | phase-rotation index to send |
| tx_amp_i | input | SYM_W-1 | side-tone amplitude magnitude |
| tx_ready_o | output | 1 | transmitter can accept an index |
| sym_valid_o | output | 1 | sym_o holds a coded BPSK symbol |
| sym_o | output | SYM_W | signed BPSK amplitude |
| rx_valid_i | input | 1 | rx_bits_i holds a received word |
| rx_bits_i | input | 5 | hard decisions, bit 4 first sent |
| dec_valid_o | output | 1 | decoded result valid |
| dec_idx_o | output | 2 | recovered index |
| dec_fixed_o | output | 1 | single error corrected |
| dec_err_o | output | 1 | uncorrectable syndrome seen |

## Verification
The hardest receive-side case is the uncorrectable outcome. Most double errors alias onto the syndrome of a single error and get miscorrected quietly. Only the error pairs that land on 110 or 111 reach the error flag. The bench therefore flips bits r2 with r1 and r4 with r1 on chosen codewords to hit both flagged syndromes. On the transmit side, the stimulus reaches the no-gap handover by holding tx_valid_i high through a whole frame, and swaps the index on the very cycle tx_ready_o returns.

// File: rtl/slm_si_pkg.sv
package slm_si_pkg;
   localparam int IDX_W = 2;
   localparam int CW_W  = 5;
   localparam int SYN_W = 3;

   // systematic encoder: data in the top two bits, three parity bits below
   function automatic logic [CW_W-1:0] si_encode(input logic [IDX_W-1:0] d);
      return {d[1], d[0], d[1], d[0], d[1] ^ d[0]};
   endfunction

   // parity-check column for each codeword bit position
   function automatic logic [SYN_W-1:0] si_hcol(input int pos);
      case (pos)
         4:       return 3'b101;
         3:       return 3'b011;
         2:       return 3'b100;
         1:       return 3'b010;
         default: return 3'b001;
      endcase
   endfunction

   function automatic logic [SYN_W-1:0] si_syndrome(input logic [CW_W-1:0] r);
      return {r[4] ^ r[2], r[3] ^ r[1], r[4] ^ r[3] ^ r[0]};
   endfunction
endpackage

// File: rtl/slm_si_enc.sv
module slm_si_enc
   import slm_si_pkg::*;
(
   input  logic [IDX_W-1:0] idx_i,
   output logic [CW_W-1:0]  cw_o
);
   always_comb cw_o = si_encode(idx_i);
endmodule

// File: rtl/slm_si_tx.sv
module slm_si_tx
   import slm_si_pkg::*;
#(
   parameter int SYM_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [CW_W-1:0]         cw_i,
   input  logic [SYM_W-2:0]        amp_i,
   output logic                    ready_o,
   output logic                    sym_valid_o,
   output logic signed [SYM_W-1:0] sym_o
);
   localparam int CNT_W = $clog2(CW_W);

   logic [CW_W-1:0]  shreg_q;
   logic [CNT_W-1:0] left_q;
   logic [SYM_W-2:0] amp_q;

   function automatic logic signed [SYM_W-1:0] bpsk(input logic b, input logic [SYM_W-2:0] a);
      logic signed [SYM_W-1:0] mag;
      mag = $signed({1'b0, a});
      return b ? -mag : mag;
   endfunction

   assign ready_o = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q     <= '0;
         left_q      <= '0;
         amp_q       <= '0;
         sym_valid_o <= 1'b0;
         sym_o       <= '0;
      end else if (load_i && ready_o) begin
         sym_o       <= bpsk(cw_i[CW_W-1], amp_i);
         sym_valid_o <= 1'b1;
         shreg_q     <= cw_i << 1;
         left_q      <= CNT_W'(CW_W - 1);
         amp_q       <= amp_i;
      end else if (!ready_o) begin
         sym_o       <= bpsk(shreg_q[CW_W-1], amp_q);
         sym_valid_o <= 1'b1;
         shreg_q     <= shreg_q << 1;
         left_q      <= left_q - 1'b1;
      end else begin
         sym_valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/slm_si_dec.sv
module slm_si_dec
   import slm_si_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [CW_W-1:0]  bits_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             fixed_o,
   output logic             err_o
);
   logic [SYN_W-1:0] syn;
   logic [CW_W-1:0]  flip;
   logic [CW_W-1:0]  repaired;
   logic             hit;

   assign syn = si_syndrome(bits_i);

   for (genvar g = 0; g < CW_W; g++) begin : g_col
      assign flip[g] = (syn == si_hcol(g));
   end

   assign repaired = bits_i ^ flip;
   assign hit      = |flip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         idx_o   <= '0;
         fixed_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            idx_o   <= repaired[CW_W-1 -: IDX_W];
            fixed_o <= hit;
            err_o   <= (syn != '0) && !hit;
         end
      end
   end
endmodule

// File: rtl/slm_si_codec.sv
module slm_si_codec
   import slm_si_pkg::*;
#(
   parameter int SYM_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_valid_i,
   input  logic [1:0]              tx_idx_i,
   input  logic [SYM_W-2:0]        tx_amp_i,
   output logic                    tx_ready_o,
   output logic                    sym_valid_o,
   output logic signed [SYM_W-1:0] sym_o,
   input  logic                    rx_valid_i,
   input  logic [4:0]              rx_bits_i,
   output logic                    dec_valid_o,
   output logic [1:0]              dec_idx_o,
   output logic                    dec_fixed_o,
   output logic                    dec_err_o
);
   if (SYM_W < 2) begin : g_bad_w
      $error("slm_si_codec: SYM_W must be at least 2");
   end

   logic [CW_W-1:0] cw;

   slm_si_enc u_enc (
      .idx_i (tx_idx_i),
      .cw_o  (cw)
   );

   slm_si_tx #(.SYM_W(SYM_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (tx_valid_i),
      .cw_i        (cw),
      .amp_i       (tx_amp_i),
      .ready_o     (tx_ready_o),
      .sym_valid_o (sym_valid_o),
      .sym_o       (sym_o)
   );

   slm_si_dec u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (rx_valid_i),
      .bits_i  (rx_bits_i),
      .valid_o (dec_valid_o),
      .idx_o   (dec_idx_o),
      .fixed_o (dec_fixed_o),
      .err_o   (dec_err_o)
   );
endmodule

// File: rtl/slm_si_codec_chk.sv
module slm_si_codec_chk
   import slm_si_pkg::*;
#(
   parameter int SYM_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tx_valid_i,
   input logic                    tx_ready_o,
   input logic                    sym_valid_o,
   input logic signed [SYM_W-1:0] sym_o,
   input logic                    rx_valid_i,
   input logic [4:0]              rx_bits_i,
   input logic                    dec_valid_o,
   input logic [1:0]              dec_idx_o,
   input logic                    dec_fixed_o,
   input logic                    dec_err_o
);
   function automatic logic [SYM_W-1:0] mag(input logic signed [SYM_W-1:0] v);
      return v[SYM_W-1] ? -v : v;
   endfunction

   AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i |=> dec_valid_o); // R5
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_i |=> !dec_valid_o); // R5
   AST_DEC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && rx_bits_i == si_encode(rx_bits_i[4:3]))
      |=> (!dec_fixed_o && !dec_err_o && dec_idx_o == $past(rx_bits_i[4:3]))); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> !(dec_fixed_o && dec_err_o)); // R8
   AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && tx_ready_o) |=> sym_valid_o); // R3
   AST_TX_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_ready_o |=> sym_valid_o); // R4
   AST_TX_AMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_ready_o |=> (mag(sym_o) == $past(mag(sym_o)))); // R2
endmodule

bind slm_si_codec slm_si_codec_chk #(.SYM_W(SYM_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid_i  (tx_valid_i),
   .tx_ready_o  (tx_ready_o),
   .sym_valid_o (sym_valid_o),
   .sym_o       (sym_o),
   .rx_valid_i  (rx_valid_i),
   .rx_bits_i   (rx_bits_i),
   .dec_valid_o (dec_valid_o),
   .dec_idx_o   (dec_idx_o),
   .dec_fixed_o (dec_fixed_o),
   .dec_err_o   (dec_err_o)
);

// File: tb/slm_si_codec_bench.sv
`timescale 1ns/1ps
module slm_si_codec_bench;
   localparam int SYM_W = 16;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    tx_valid_i = 1'b0;
   logic [1:0]              tx_idx_i = '0;
   logic [SYM_W-2:0]        tx_amp_i = '0;
   logic                    tx_ready_o;
   logic                    sym_valid_o;
   logic signed [SYM_W-1:0] sym_o;
   logic                    rx_valid_i = 1'b0;
   logic [4:0]              rx_bits_i = '0;
   logic                    dec_valid_o;
   logic [1:0]              dec_idx_o;
   logic                    dec_fixed_o;
   logic                    dec_err_o;

   int total = 0;
   int fails = 0;

   always #10 clk = ~clk;

   slm_si_codec #(.SYM_W(SYM_W)) u_slm_si_codec (.*);

   function automatic logic [4:0] ref_cw(input logic [1:0] d);
      case (d)
         2'b00:   return 5'b00000;
         2'b01:   return 5'b01011;
         2'b10:   return 5'b10101;
         default: return 5'b11110;
      endcase
   endfunction

   function automatic logic [SYM_W-1:0] ref_sym(input logic b, input logic [SYM_W-2:0] a);
      return b ? (SYM_W'(0) - {1'b0, a}) : {1'b0, a};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(tx_ready_o == 1'b1, "R9 ready", 32'(tx_ready_o), 1);
      check(sym_valid_o == 1'b0, "R9 sym_valid", 32'(sym_valid_o), 0);
      check({dec_valid_o, dec_fixed_o, dec_err_o} == 3'b000, "R9 dec flags",
            32'({dec_valid_o, dec_fixed_o, dec_err_o}), 0);
   endtask

   // one frame; amplitude is changed after acceptance to show it was captured
   task automatic t_frame(input logic [1:0] d, input logic [SYM_W-2:0] a);
      logic [4:0] cw;
      cw = ref_cw(d);
      @(negedge clk);
      tx_valid_i = 1'b1; tx_idx_i = d; tx_amp_i = a;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (i == 0) begin tx_valid_i = 1'b0; tx_amp_i = ~a; end
         check(sym_valid_o == 1'b1, "R3 symbol valid", 32'(sym_valid_o), 1);
         check(sym_o == ref_sym(cw[4-i], a), "R1 R2 symbol value", 32'(sym_o), 32'(ref_sym(cw[4-i], a)));
      end
      @(negedge clk);
      check(sym_valid_o == 1'b0, "R3 frame length", 32'(sym_valid_o), 0);
   endtask

   // index offered while busy must not disturb the frame nor start another
   task automatic t_busy_ignore();
      logic [4:0] cw;
      cw = ref_cw(2'b10);
      @(negedge clk);
      tx_valid_i = 1'b1; tx_idx_i = 2'b10; tx_amp_i = 15'h1234;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (i == 0) begin
            check(tx_ready_o == 1'b0, "R4 ready low", 32'(tx_ready_o), 0);
            tx_idx_i = 2'b01;
         end
         if (i == 3) tx_valid_i = 1'b0;
         check(sym_o == ref_sym(cw[4-i], 15'h1234), "R4 busy ignore", 32'(sym_o),
               32'(ref_sym(cw[4-i], 15'h1234)));
      end
      @(negedge clk);
      check(sym_valid_o == 1'b0, "R4 no extra frame", 32'(sym_valid_o), 0);
   endtask

   task automatic t_back_to_back();
      logic [9:0] both;
      both = {ref_cw(2'b11), ref_cw(2'b01)};
      @(negedge clk);
      tx_valid_i = 1'b1; tx_idx_i = 2'b11; tx_amp_i = 15'h0100;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(sym_valid_o == 1'b1, "R4 gapless valid", 32'(sym_valid_o), 1);
         check(sym_o == ref_sym(both[9-i], 15'h0100), "R4 gapless symbol", 32'(sym_o),
               32'(ref_sym(both[9-i], 15'h0100)));
         if (i == 4) begin
            check(tx_ready_o == 1'b1, "R4 ready on last", 32'(tx_ready_o), 1);
            tx_idx_i = 2'b01;
         end
         if (i == 5) tx_valid_i = 1'b0;
      end
      @(negedge clk);
      check(sym_valid_o == 1'b0, "R3 after second frame", 32'(sym_valid_o), 0);
   endtask

   task automatic t_dec(input logic [4:0] r, input logic [1:0] ei, input logic ef,
                        input logic ee, input string tag);
      @(negedge clk);
      rx_valid_i = 1'b1; rx_bits_i = r;
      @(negedge clk);
      rx_valid_i = 1'b0; rx_bits_i = ~r;
      check(dec_valid_o == 1'b1, "R5 dec valid", 32'(dec_valid_o), 1);
      check({dec_idx_o, dec_fixed_o, dec_err_o} == {ei, ef, ee}, tag,
            32'({dec_idx_o, dec_fixed_o, dec_err_o}), 32'({ei, ef, ee}));
      @(negedge clk);
      check(dec_valid_o == 1'b0, "R5 dec idle", 32'(dec_valid_o), 0);
   endtask

   task automatic t_dec_clean();
      for (int d = 0; d < 4; d++)
         t_dec(ref_cw(2'(d)), 2'(d), 1'b0, 1'b0, "R6 clean word");
   endtask

   task automatic t_dec_single();
      for (int d = 0; d < 4; d++)
         for (int p = 0; p < 5; p++)
            t_dec(ref_cw(2'(d)) ^ (5'b1 << p), 2'(d), 1'b1, 1'b0, "R7 single error");
   endtask

   task automatic t_dec_double();
      // r2,r1 -> syndrome 110 ; r4,r1 -> syndrome 111
      t_dec(ref_cw(2'b01) ^ 5'b00110, 2'b01, 1'b0, 1'b1, "R8 syndrome 110");
      t_dec(ref_cw(2'b00) ^ 5'b10010, 2'b10, 1'b0, 1'b1, "R8 syndrome 111 raw idx");
      t_dec(ref_cw(2'b11) ^ 5'b00110, 2'b11, 1'b0, 1'b1, "R8 syndrome 110 idx 3");
   endtask

   initial begin
      #(20 * 100000);
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_frame(2'b00, 15'h2000);
      t_frame(2'b01, 15'h7fff);
      t_frame(2'b10, 15'h0005);
      t_frame(2'b11, 15'h4abc);
      t_busy_ignore();
      t_back_to_back();
      t_dec_clean();
      t_dec_single();
      t_dec_double();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule